// File: doc/BRIEF.md
# Parallel Scalar Coefficient Quantizer

This block turns a full 4x4 block of integer-transform coefficients into quantized levels in one clock. Each of sixteen identical lanes handles one coefficient. A lane takes the magnitude of the coefficient, multiplies it by a factor chosen from the quantization parameter and the coefficient's place in the block, adds a rounding offset, shifts right, and then puts the sign back. The offset is larger for intra-coded blocks than for inter-coded ones.

The QP decode that gives the shift amount, the table row and the offset is shared by all lanes. Each lane has two register stages. The first holds the 27-bit product. The second holds the shifted and signed 16-bit level. A new block can be presented on every clock, so the block keeps pace with a transform stage that makes one block per cycle.

Top module: `qz_array`

## Requirements
- R1: After reset, `out_valid` is 0 and every level in `level_flat` is 0.
- R2: `out_valid` rises exactly two rising edges after the edge that samples `in_valid`=1, and stays 0 for blocks that were not presented.
- R3: For intra blocks (`intra`=1), the magnitude is floor((|W|*MF + floor(2^qb/3)) / 2^qb).
- R4: For inter blocks (`intra`=0), the rounding offset is floor(2^qb/6) instead.
- R5: The shift is qb = 15 + floor(QP/6). The MF row is picked by QP mod 6, with the classes {both-even, both-odd, mixed} as follows: row 0 {13107,5243,8066}, row 1 {11916,4660,7490}, row 2 {10082,4194,6554}, row 3 {9362,3647,5825}, row 4 {8192,3355,5243}, row 5 {7282,2893,4559}.
- R6: Coefficient k sits in `coef_flat[13k+12:13k]` at row k>>2 and column k&3, and its level is in `level_flat[16k+15:16k]`. The MF class is "both-even" when row and column are both even, "both-odd" when both are odd, and "mixed" otherwise.
- R7: A negative coefficient yields the two's-complement negation of its magnitude result. A zero coefficient yields level 0.
- R8: QP codes 52..63 are treated as QP 51.
- R9: Blocks presented on consecutive clocks are each quantized with their own QP and mode, with no stall.
- R10: While no block is in flight, the levels hold their last values even if the coefficient inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented this cycle |
| qp | input | 6 | Quantization parameter (0..51; higher codes clamp) |
| intra | input | 1 | 1 = intra rounding offset, 0 = inter |
| coef_flat | input | 208 | Sixteen signed 13-bit coefficients, raster order |
| out_valid | output | 1 | Levels on `level_flat` belong to a new block |
| level_flat | output | 256 | Sixteen signed 16-bit levels, raster order |

## Verification
Every level and `out_valid` are due two rising edges after the edge that samples the block. The bench drives inputs on falling edges. For single blocks, it checks one falling edge after the first rising edge that `out_valid` is still low, and compares the data on the next falling edge. In the streaming test, the block driven at falling edge n is compared at falling edge n+2, so each comparison lines up with its own QP and mode. The hold test changes the inputs while `in_valid` is low and samples on the following falling edges.

// File: rtl/qz_pkg.sv
package qz_pkg;
  localparam int unsigned COEF_W  = 13;
  localparam int unsigned LEVEL_W = 16;
  localparam int unsigned PROD_W  = 27;
  localparam int unsigned MF_W    = 14;
  localparam int unsigned QP_W    = 6;
  localparam int unsigned QB_W    = 5;
  localparam int unsigned QP_TOP  = 51;
  localparam int unsigned QB_BASE = 15;
  localparam int unsigned LANES   = 16;

  // class 0: row and column even, 1: both odd, 2: mixed
  function automatic logic [1:0] pos_class(input int unsigned lane);
    logic r_odd, c_odd;
    r_odd = lane[2];
    c_odd = lane[0];
    if (!r_odd && !c_odd) return 2'd0;
    if (r_odd && c_odd)   return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [MF_W-1:0] mf_pick(input logic [2:0] rem, input logic [1:0] cls);
    logic [MF_W-1:0] v;
    case ({rem, cls})
      {3'd0, 2'd0}: v = 14'd13107;
      {3'd0, 2'd1}: v = 14'd5243;
      {3'd0, 2'd2}: v = 14'd8066;
      {3'd1, 2'd0}: v = 14'd11916;
      {3'd1, 2'd1}: v = 14'd4660;
      {3'd1, 2'd2}: v = 14'd7490;
      {3'd2, 2'd0}: v = 14'd10082;
      {3'd2, 2'd1}: v = 14'd4194;
      {3'd2, 2'd2}: v = 14'd6554;
      {3'd3, 2'd0}: v = 14'd9362;
      {3'd3, 2'd1}: v = 14'd3647;
      {3'd3, 2'd2}: v = 14'd5825;
      {3'd4, 2'd0}: v = 14'd8192;
      {3'd4, 2'd1}: v = 14'd3355;
      {3'd4, 2'd2}: v = 14'd5243;
      {3'd5, 2'd0}: v = 14'd7282;
      {3'd5, 2'd1}: v = 14'd2893;
      {3'd5, 2'd2}: v = 14'd4559;
      default:      v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [PROD_W-1:0] round_off(input logic [QB_W-1:0] qb, input logic intra);
    logic [PROD_W-1:0] full;
    full = PROD_W'(1) << qb;
    return intra ? full / PROD_W'(3) : full / PROD_W'(6);
  endfunction
endpackage

// File: rtl/qz_qp_decode.sv
module qz_qp_decode
  import qz_pkg::*;
(
  input  logic [QP_W-1:0]   qp,
  input  logic              intra,
  output logic [2:0]        rem,
  output logic [QB_W-1:0]   qbits,
  output logic [PROD_W-1:0] offset
);
  logic [QP_W-1:0] qp_eff;
  logic [QP_W-1:0] per;

  always_comb begin
    qp_eff = (qp > QP_W'(QP_TOP)) ? QP_W'(QP_TOP) : qp;
    per    = qp_eff / QP_W'(6);
    rem    = 3'(qp_eff % QP_W'(6));
    qbits  = QB_W'(QB_BASE) + QB_W'(per);
    offset = round_off(qbits, intra);
  end
endmodule

// File: rtl/qz_lane.sv
module qz_lane
  import qz_pkg::*;
#(
  parameter int unsigned LANE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [2:0]          rem,
  input  logic [COEF_W-1:0]   coef,
  input  logic                s1_vld,
  input  logic [QB_W-1:0]     s1_qbits,
  input  logic [PROD_W-1:0]   s1_off,
  output logic [LEVEL_W-1:0]  level
);
  localparam logic [1:0] CLS = pos_class(LANE);

  logic [COEF_W-1:0]  mag;
  logic [MF_W-1:0]    mf;
  logic [PROD_W-1:0]  prod_c, prod_q;
  logic               neg_q;
  logic [PROD_W-1:0]  sum_c, shifted;
  logic [LEVEL_W-1:0] mag_o;

  always_comb begin
    mag    = coef[COEF_W-1] ? (~coef + COEF_W'(1)) : coef;
    mf     = mf_pick(rem, CLS);
    prod_c = PROD_W'(mag) * PROD_W'(mf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      neg_q  <= 1'b0;
    end else if (in_vld) begin
      prod_q <= prod_c;
      neg_q  <= coef[COEF_W-1];
    end
  end

  always_comb begin
    sum_c   = prod_q + s1_off;
    shifted = sum_c >> s1_qbits;
    mag_o   = shifted[LEVEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       level <= '0;
    else if (s1_vld)  level <= neg_q ? (LEVEL_W'(0) - mag_o) : mag_o;
  end

  // R3: the trimmed result never needs more than the level width
  a_r3_fits: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (shifted[PROD_W-1:LEVEL_W-1] == '0));
  // R7: a zero product gives a zero level
  a_r7_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && prod_q == '0) |=> (level == '0));
  // R7: a negative coefficient never gives a positive level
  a_r7_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && neg_q) |=> (level[LEVEL_W-1] || level == '0));
  // R10: idle pipeline keeps the level
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(level));
endmodule

// File: rtl/qz_array.sv
module qz_array
  import qz_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [QP_W-1:0]          qp,
  input  logic                     intra,
  input  logic [LANES*COEF_W-1:0]  coef_flat,
  output logic                     out_valid,
  output logic [LANES*LEVEL_W-1:0] level_flat
);
  logic [2:0]        rem_c;
  logic [QB_W-1:0]   qb_c, s1_qb;
  logic [PROD_W-1:0] off_c, s1_off;
  logic              s1_vld;

  qz_qp_decode dec_i (
    .qp(qp), .intra(intra), .rem(rem_c), .qbits(qb_c), .offset(off_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_qb     <= '0;
      s1_off    <= '0;
      out_valid <= 1'b0;
    end else begin
      s1_vld    <= in_valid;
      out_valid <= s1_vld;
      if (in_valid) begin
        s1_qb  <= qb_c;
        s1_off <= off_c;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    qz_lane #(.LANE(k)) lane_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_valid), .rem(rem_c),
      .coef(coef_flat[k*COEF_W +: COEF_W]),
      .s1_vld(s1_vld), .s1_qbits(s1_qb), .s1_off(s1_off),
      .level(level_flat[k*LEVEL_W +: LEVEL_W])
    );
  end

  // R2: valid travels through both stages
  a_r2_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_vld);
  a_r2_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_valid);
  // R8: out-of-range QP decodes as QP 51
  a_r8_qp_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (qp > QP_W'(QP_TOP)) |-> (qb_c == QB_W'(23) && rem_c == 3'd3));
endmodule

// File: tb/qz_array_tb_top.sv
`timescale 1ns/1ps
module qz_array_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [5:0]   qp;
  logic         intra;
  logic [207:0] coef_flat;
  logic         out_valid;
  logic [255:0] level_flat;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  qz_array dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .qp(qp), .intra(intra),
    .coef_flat(coef_flat), .out_valid(out_valid), .level_flat(level_flat)
  );

  int cf [16];

  function automatic longint mf_ref(int q, int k);
    int r, c, cls;
    int even_t [6] = '{13107, 11916, 10082, 9362, 8192, 7282};
    int odd_t  [6] = '{5243, 4660, 4194, 3647, 3355, 2893};
    int mix_t  [6] = '{8066, 7490, 6554, 5825, 5243, 4559};
    r = k / 4; c = k % 4;
    if ((r % 2) == 0 && (c % 2) == 0) return even_t[q % 6];
    if ((r % 2) == 1 && (c % 2) == 1) return odd_t[q % 6];
    return mix_t[q % 6];
  endfunction

  function automatic int exp_level(int w, int k, int qp_in, bit in_intra);
    int q, qb;
    longint a, f, m;
    q  = (qp_in > 51) ? 51 : qp_in;
    qb = 15 + q / 6;
    f  = in_intra ? ((64'd1 << qb) / 3) : ((64'd1 << qb) / 6);
    a  = (w < 0) ? -w : w;
    m  = (a * mf_ref(q, k) + f) >>> qb;
    return (w < 0) ? -int'(m) : int'(m);
  endfunction

  function automatic int gen(int seed, int k);
    return ((seed * 37 + k * 211 + seed * k * 13) % 7141) - 3060;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_coefs();
    for (int k = 0; k < 16; k++) coef_flat[k*13 +: 13] = 13'(cf[k]);
  endtask

  function automatic int lvl(int k);
    return int'($signed(level_flat[k*16 +: 16]));
  endfunction

  task automatic check_levels(int q, bit in_intra, string req);
    for (int k = 0; k < 16; k++) begin
      int e;
      e = exp_level(cf[k], k, q, in_intra);
      chk(lvl(k) == e, req, lvl(k), e);
    end
  endtask

  task automatic run_block(int q, bit in_intra, string req);
    @(negedge clk);
    put_coefs();
    qp = 6'(q); intra = in_intra; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R2 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 due", out_valid, 1);
    check_levels(q, in_intra, req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; qp = '0; intra = 1'b0; coef_flat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(level_flat == '0, "R1 levels", level_flat == '0, 1);
  endtask

  task automatic t_intra();
    for (int k = 0; k < 16; k++) cf[k] = gen(3, k);
    run_block(28, 1'b1, "R3 R6 intra");
  endtask

  task automatic t_inter();
    for (int k = 0; k < 16; k++) cf[k] = gen(3, k);
    run_block(28, 1'b0, "R4 inter");
  endtask

  task automatic t_qp_sweep();
    for (int q = 0; q < 52; q++) begin
      for (int k = 0; k < 16; k++) cf[k] = gen(q + 7, k);
      run_block(q, q[0], "R5 qp sweep");
    end
  endtask

  task automatic t_signs();
    cf = '{0, -1, 1, -3060, 4080, -4080, 3060, 0, -17, 17, -2048, 2048, -5, 5, 0, -1000};
    run_block(0, 1'b1, "R7 signs qp0");
    run_block(51, 1'b0, "R7 signs qp51");
    run_block(12, 1'b1, "R7 signs qp12");
  endtask

  task automatic t_qp_over();
    for (int k = 0; k < 16; k++) cf[k] = gen(11, k);
    run_block(52, 1'b1, "R8 qp52");
    run_block(63, 1'b0, "R8 qp63");
  endtask

  task automatic t_stream();
    int sq [4] = '{0, 51, 20, 33};
    bit si [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
    int sc [4][16];
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 16; k++) sc[b][k] = gen(b * 5 + 40, k);
    for (int cyc = 0; cyc < 6; cyc++) begin
      @(negedge clk);
      if (cyc >= 2) begin
        chk(out_valid == 1'b1, "R9 stream valid", out_valid, 1);
        for (int k = 0; k < 16; k++) begin
          int e;
          e = exp_level(sc[cyc-2][k], k, sq[cyc-2], si[cyc-2]);
          chk(lvl(k) == e, "R9 stream level", lvl(k), e);
        end
      end
      if (cyc < 4) begin
        for (int k = 0; k < 16; k++) cf[k] = sc[cyc][k];
        put_coefs();
        qp = 6'(sq[cyc]); intra = si[cyc]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 after stream", out_valid, 0);
  endtask

  task automatic t_hold();
    logic [255:0] snap;
    for (int k = 0; k < 16; k++) cf[k] = gen(99, k);
    run_block(17, 1'b1, "R10 setup");
    snap = level_flat;
    for (int k = 0; k < 16; k++) cf[k] = gen(123, k);
    put_coefs();
    qp = 6'd3; intra = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(level_flat == snap, "R10 hold", level_flat == snap, 1);
      chk(out_valid == 1'b0, "R10 idle valid", out_valid, 0);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_intra();
    t_inter();
    t_signs();
    t_qp_over();
    t_qp_sweep();
    t_stream();
    t_hold();
    finish_run();
  end
endmodule